// File: doc/BRIEF.md
# Overshift-Aware Shift Unit

This unit is the shift datapath of a fixed-point execution pipe. Its operand is either a full 64-bit value or the low 32-bit word of one. It does three things: logical shifts to the left, logical shifts to the right, and arithmetic shifts to the right. The shift count comes either from a register operand or from a short immediate field. A register count carries one extra bit above the operand's index range. When that bit is set, the count is an overshift, and the unit then returns a fixed result instead of a wrapped one.

Internally, every operation uses one shared left rotator and a per-bit mask generator. A right shift by n is a left rotation by the width minus n, with a mask of ones that covers only the surviving bits. For arithmetic shifts, the bits outside that mask take the sign. The bits that lie outside the mask and inside the operand width are the bits shifted out. The carry comes from them.

The unit also produces a three-bit signed comparison of the result against zero. This value is written when the record flag is set. Results appear one clock after the request.

Top module: `shift_unit`

## Requirements
- R1: A request sampled with `in_valid` high at a rising edge is presented on the outputs after that edge, with `out_valid` high. A cycle without a request leaves `out_valid`, `ca_we` and `cr_we` low. Synchronous reset clears all outputs to zero.
- R2: In 64-bit mode (`is_word`=0) a register count is `amt_reg[6:0]`. A count from 64 to 127 gives a logical shift result of zero.
- R3: In 32-bit mode (`is_word`=1) a register count is `amt_reg[5:0]`, and a count from 32 to 63 gives a logical result of zero. Word operations read only `src[31:0]`, and logical word results have bits 63:32 equal to zero.
- R4: Logical shifts fill vacated positions with zeros. A left shift discards bits moved past bit 63, or past bit 31 in word mode. A right shift discards bits moved below bit 0.
- R5: An arithmetic right shift fills vacated positions with the sign bit: `src[63]` in 64-bit mode, `src[31]` in word mode. A word result is sign-extended through bit 63.
- R6: The carry `ca` is 1 exactly when the sign bit of the operand is 1 and at least one 1-bit of the operand is shifted out; otherwise it is 0.
- R7: An arithmetic shift by zero returns the sign-extended operand and clears the carry.
- R8: An arithmetic overshift returns all bits equal to the sign bit, and the carry equals the sign bit.
- R9: With `use_imm`=1 the count is `amt_imm[5:0]` in 64-bit mode and `amt_imm[4:0]` in word mode (bit 5 ignored). An immediate count never overshifts, and `amt_reg` has no effect.
- R10: `ca_we` is high only for an arithmetic right shift. For every other operation `ca` is 0.
- R11: `cr_we` follows `record`. `cr` encodes a signed comparison of the full 64-bit result with zero: bit 2 less-than, bit 1 greater-than, bit 0 equal. Exactly one bit is set when `cr_we` is high.
- R12: `op_sel` encodes 0 = shift left logical, 1 = shift right logical, 2 = shift right arithmetic. Code 3 is reserved and gives a zero result with no carry write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Operation code |
| is_word | input | 1 | 1 = 32-bit operand, 0 = 64-bit operand |
| use_imm | input | 1 | 1 = take count from `amt_imm` |
| record | input | 1 | Request a condition-field update |
| src | input | 64 | Operand to shift |
| amt_reg | input | 64 | Register holding the shift count |
| amt_imm | input | 6 | Immediate shift count |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Shift result |
| ca | output | 1 | Carry from arithmetic right shift |
| ca_we | output | 1 | Carry write enable |
| cr | output | 3 | Condition bits {lt, gt, eq} |
| cr_we | output | 1 | Condition write enable |

## Verification
The bench targets the count boundaries 63/64 and 31/32. A design that wraps the count or ignores the overshift bit returns a rotated or partly shifted value there instead of zero or the sign fill.

Zero-count and overshift arithmetic shifts on negative operands are driven directly. They catch a carry computed from the wrong bits, or a carry left set when nothing was shifted out.

Word-mode inputs carry garbage in `src[63:32]` and in the unused count bits, so that a design reading the wrong half or the wrong count bit is exposed. Word results with bit 31 set also exercise sign extension and the signed compare behind `cr`.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int AMT_W  = $clog2(DATA_W);
    localparam int CR_W   = 3;

    typedef enum logic [1:0] {
        OP_SLL = 2'd0,
        OP_SRL = 2'd1,
        OP_SRA = 2'd2,
        OP_RSV = 2'd3
    } shift_op_e;

    typedef struct packed {
        logic [AMT_W-1:0] n;
        logic             over;
    } shift_amt_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
        logic              carry_we;
    } shift_res_t;

    function automatic logic [CR_W-1:0] sign_compare(input logic [DATA_W-1:0] v);
        logic [CR_W-1:0] c;
        if (v[DATA_W-1])
            c = 3'b100;
        else if (v != '0)
            c = 3'b010;
        else
            c = 3'b001;
        return c;
    endfunction

endpackage

// File: rtl/shift_amount.sv
module shift_amount
    import shift_unit_pkg::*;
(
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [AMT_W-1:0]  amt_imm,
    input  logic              use_imm,
    input  logic              is_word,
    output shift_amt_t        amt
);
    localparam int WAMT_W = AMT_W - 1;

    always_comb begin
        amt.n    = '0;
        amt.over = 1'b0;
        if (use_imm) begin
            if (is_word)
                amt.n = {1'b0, amt_imm[WAMT_W-1:0]};
            else
                amt.n = amt_imm;
        end else begin
            if (is_word) begin
                amt.n    = {1'b0, amt_reg[WAMT_W-1:0]};
                amt.over = amt_reg[WAMT_W];
            end else begin
                amt.n    = amt_reg[AMT_W-1:0];
                amt.over = amt_reg[AMT_W];
            end
        end
    end
endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_unit_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  shift_amt_t        amt,
    input  logic              is_word,
    input  shift_op_e         op,
    output shift_res_t        res
);
    logic              go_left;
    logic [AMT_W-1:0]  rot_n;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] rotated;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] lost_bits;
    logic              sign;

    assign go_left    = (op == OP_SLL);
    assign rot_n      = go_left ? amt.n : (AMT_W'(0) - amt.n);
    assign operand    = is_word ? {src[HALF_W-1:0], src[HALF_W-1:0]} : src;
    assign sign       = is_word ? src[HALF_W-1] : src[DATA_W-1];
    assign width_mask = is_word ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};

    // Logarithmic left rotator, one stage per count bit.
    logic [DATA_W-1:0] stage [AMT_W+1];
    assign stage[0] = operand;
    for (genvar s = 0; s < AMT_W; s++) begin : g_rot
        localparam int SH = 1 << s;
        assign stage[s+1] = rot_n[s] ? ((stage[s] << SH) | (stage[s] >> (DATA_W - SH)))
                                     : stage[s];
    end
    assign rotated = stage[AMT_W];

    // Per-bit mask: which rotated bits survive the shift.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        localparam logic [AMT_W:0] IDX      = (AMT_W+1)'(i);
        localparam logic [AMT_W:0] ROOM_DW  = (AMT_W+1)'(DATA_W - 1 - i);
        localparam logic [AMT_W:0] ROOM_W   = (i < HALF_W) ? (AMT_W+1)'(HALF_W - 1 - i)
                                                           : (AMT_W+1)'(0);
        localparam bit             IN_WORD  = (i < HALF_W);
        logic keep_l;
        logic keep_r;
        always_comb begin
            keep_l = (IDX >= {1'b0, amt.n});
            if (is_word)
                keep_r = IN_WORD && ({1'b0, amt.n} <= ROOM_W);
            else
                keep_r = ({1'b0, amt.n} <= ROOM_DW);
            if (is_word && !IN_WORD)
                keep_l = 1'b0;
        end
        assign keep_mask[i] = !amt.over && (go_left ? keep_l : keep_r);
    end

    assign lost_bits = rotated & ~keep_mask & width_mask;

    always_comb begin
        res = '0;
        unique case (op)
            OP_SLL, OP_SRL: res.value = rotated & keep_mask;
            OP_SRA: begin
                res.value    = (rotated & keep_mask) | ({DATA_W{sign}} & ~keep_mask);
                res.carry    = sign & (|lost_bits);
                res.carry_we = 1'b1;
            end
            default: res = '0;
        endcase
    end

    // R6: a carry is only ever produced for a negative operand
    always_comb begin
        a_ca_sign_r6: assert (!res.carry || sign)
            else $error("carry without negative operand");
    end
endmodule

// File: rtl/shift_flags.sv
module shift_flags
    import shift_unit_pkg::*;
(
    input  logic [DATA_W-1:0] value,
    input  logic              record,
    output logic [CR_W-1:0]   cr,
    output logic              cr_we
);
    assign cr    = sign_compare(value);
    assign cr_we = record;
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic              is_word,
    input  logic              use_imm,
    input  logic              record,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic [AMT_W-1:0]  amt_imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              ca,
    output logic              ca_we,
    output logic [CR_W-1:0]   cr,
    output logic              cr_we
);
    shift_amt_t       amt;
    shift_res_t       res;
    shift_op_e        op;
    logic [CR_W-1:0]  cr_d;
    logic             cr_we_d;

    assign op = shift_op_e'(op_sel);

    shift_amount u_amount (
        .amt_reg (amt_reg),
        .amt_imm (amt_imm),
        .use_imm (use_imm),
        .is_word (is_word),
        .amt     (amt)
    );

    shift_core u_core (
        .src     (src),
        .amt     (amt),
        .is_word (is_word),
        .op      (op),
        .res     (res)
    );

    shift_flags u_flags (
        .value  (res.value),
        .record (record),
        .cr     (cr_d),
        .cr_we  (cr_we_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            ca        <= 1'b0;
            ca_we     <= 1'b0;
            cr        <= '0;
            cr_we     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            ca_we     <= in_valid && res.carry_we;
            cr_we     <= in_valid && cr_we_d;
            if (in_valid) begin
                result <= res.value;
                ca     <= res.carry;
                cr     <= cr_d;
            end
        end
    end

    // R8/R6: carry register only high after a negative operand
    p_ca_neg_r6: assert property (@(posedge clk) disable iff (rst)
        ca |-> $past(is_word ? src[HALF_W-1] : src[DATA_W-1]))
        else $error("carry set for non-negative operand");

    // R2/R3: logical overshift yields zero
    p_over_zero_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(amt.over && (op == OP_SLL || op == OP_SRL)) |-> result == '0)
        else $error("logical overshift not zero");

    p_word_hi_zero_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(is_word && (op == OP_SLL || op == OP_SRL)) |-> result[DATA_W-1:HALF_W] == '0)
        else $error("logical word result has upper bits");

    p_zero_amt_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(op == OP_SRA && amt.n == '0 && !amt.over) |-> !ca)
        else $error("zero count produced carry");

    p_ca_we_r10: assert property (@(posedge clk) disable iff (rst)
        ca_we |-> out_valid && $past(op == OP_SRA))
        else $error("carry write outside arithmetic shift");

    p_cr_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> $countones(cr) == 1)
        else $error("condition bits not one-hot");

    p_valid_r1: assert property (@(posedge clk) disable iff (rst)
        (ca_we || cr_we) |-> out_valid)
        else $error("write enable without valid");
endmodule

// File: tb/shift_unit_tb_top.sv
module shift_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op_sel;
    logic        is_word;
    logic        use_imm;
    logic        record;
    logic [63:0] src;
    logic [63:0] amt_reg;
    logic [5:0]  amt_imm;
    logic        out_valid;
    logic [63:0] result;
    logic        ca;
    logic        ca_we;
    logic [2:0]  cr;
    logic        cr_we;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    shift_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .is_word(is_word), .use_imm(use_imm), .record(record), .src(src),
        .amt_reg(amt_reg), .amt_imm(amt_imm), .out_valid(out_valid),
        .result(result), .ca(ca), .ca_we(ca_we), .cr(cr), .cr_we(cr_we)
    );

    // Reference model written straight from the requirements.
    task automatic model(input logic [1:0] op, input logic w, input logic im,
                         input logic [63:0] s, input logic [63:0] ar, input logic [5:0] ai,
                         output logic [63:0] r, output logic c, output logic cwe);
        int   n;
        logic ov;
        logic sg;
        logic [31:0] x;
        x = s[31:0];
        if (im) begin
            n  = w ? int'(ai[4:0]) : int'(ai);
            ov = 1'b0;
        end else if (w) begin
            n  = int'(ar[4:0]);
            ov = ar[5];
        end else begin
            n  = int'(ar[5:0]);
            ov = ar[6];
        end
        r = '0; c = 1'b0; cwe = 1'b0;
        if (w) begin
            sg = x[31];
            case (op)
                2'd0: r = ov ? 64'd0 : {32'd0, x << n};
                2'd1: r = ov ? 64'd0 : {32'd0, x >> n};
                2'd2: begin
                    logic [31:0] t;
                    t   = ov ? {32{sg}} : 32'($signed(x) >>> n);
                    r   = {{32{t[31]}}, t};
                    c   = sg && (ov ? (x != 0) : ((x & ((32'd1 << n) - 32'd1)) != 0));
                    cwe = 1'b1;
                end
                default: r = '0;
            endcase
        end else begin
            sg = s[63];
            case (op)
                2'd0: r = ov ? 64'd0 : s << n;
                2'd1: r = ov ? 64'd0 : s >> n;
                2'd2: begin
                    r   = ov ? {64{sg}} : 64'($signed(s) >>> n);
                    c   = sg && (ov ? (s != 0) : ((s & ((64'd1 << n) - 64'd1)) != 0));
                    cwe = 1'b1;
                end
                default: r = '0;
            endcase
        end
    endtask

    task automatic apply(input string tag, input logic [1:0] op, input logic w,
                         input logic im, input logic rec, input logic [63:0] s,
                         input logic [63:0] ar, input logic [5:0] ai);
        logic [63:0] er;
        logic        ec, ecwe;
        logic [2:0]  ecr;
        model(op, w, im, s, ar, ai, er, ec, ecwe);
        ecr = $signed(er) < 0 ? 3'b100 : (er != 0 ? 3'b010 : 3'b001);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; is_word = w; use_imm = im; record = rec;
        src = s; amt_reg = ar; amt_imm = ai;
        @(negedge clk);
        in_valid = 1'b0;
        n_vec++;
        if (out_valid !== 1'b1 || result !== er || ca_we !== ecwe ||
            (ecwe && ca !== ec) || (!ecwe && ca !== 1'b0) ||
            cr_we !== rec || (rec && cr !== ecr)) begin
            n_fail++;
            $display("FAIL %s: op=%0d w=%0b got res=%h ca=%0b cawe=%0b cr=%b crwe=%0b v=%0b exp res=%h ca=%0b cawe=%0b cr=%b crwe=%0b",
                     tag, op, w, result, ca, ca_we, cr, cr_we, out_valid,
                     er, ec, ecwe, ecr, rec);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1: watchdog expired, got hang exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst = 1'b1; in_valid = 0; op_sel = 0; is_word = 0; use_imm = 0; record = 0;
        src = '0; amt_reg = '0; amt_imm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (out_valid !== 0 || result !== 0 || ca !== 0 || ca_we !== 0 || cr !== 0 || cr_we !== 0) begin
            n_fail++;
            $display("FAIL R1: reset state got v=%0b res=%h exp all zero", out_valid, result);
        end
        rst = 1'b0;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 0 || ca_we !== 0 || cr_we !== 0) begin
            n_fail++;
            $display("FAIL R1: idle got v=%0b cawe=%0b crwe=%0b exp 0 0 0", out_valid, ca_we, cr_we);
        end

        // Directed corner cases
        apply("R2", 2'd0, 0, 0, 1, 64'hFFFF_0000_1234_5678, 64'd63, 6'd0);
        apply("R2", 2'd0, 0, 0, 1, 64'hFFFF_0000_1234_5678, 64'd64, 6'd0);
        apply("R2", 2'd1, 0, 0, 1, 64'h8000_0000_0000_0001, 64'd127, 6'd0);
        apply("R2", 2'd1, 0, 0, 0, 64'h8000_0000_0000_0001, 64'hFFFF_FF00_0000_0080, 6'd0);
        apply("R3", 2'd0, 1, 0, 1, 64'hDEAD_BEEF_8000_0001, 64'hFF00_0000_0000_001F, 6'd0);
        apply("R3", 2'd1, 1, 0, 1, 64'hDEAD_BEEF_8000_0001, 64'd32, 6'd0);
        apply("R3", 2'd1, 1, 0, 1, 64'hDEAD_BEEF_F000_000F, 64'hFFC0, 6'd0);
        apply("R4", 2'd0, 0, 0, 1, 64'h0123_4567_89AB_CDEF, 64'd4, 6'd0);
        apply("R4", 2'd1, 1, 0, 1, 64'hFFFF_FFFF_8765_4321, 64'd8, 6'd0);
        apply("R5", 2'd2, 0, 0, 1, 64'h8000_0000_0000_0000, 64'd63, 6'd0);
        apply("R5", 2'd2, 1, 0, 1, 64'h0000_0000_8000_0000, 64'd4, 6'd0);
        apply("R6", 2'd2, 0, 0, 0, 64'hF000_0000_0000_0010, 64'd4, 6'd0);
        apply("R6", 2'd2, 0, 0, 0, 64'hF000_0000_0000_0010, 64'd5, 6'd0);
        apply("R6", 2'd2, 0, 0, 0, 64'h7000_0000_0000_00FF, 64'd8, 6'd0);
        apply("R7", 2'd2, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 6'd0);
        apply("R7", 2'd2, 1, 0, 1, 64'h1234_5678_9ABC_DEF0, 64'd0, 6'd0);
        apply("R8", 2'd2, 0, 0, 1, 64'h8000_0000_0000_0000, 64'd64, 6'd0);
        apply("R8", 2'd2, 1, 0, 1, 64'h0000_0000_8000_0000, 64'd63, 6'd0);
        apply("R8", 2'd2, 0, 0, 1, 64'h4000_0000_0000_0000, 64'd100, 6'd0);
        apply("R9", 2'd2, 0, 1, 1, 64'hF000_0000_0000_0001, 64'd127, 6'd63);
        apply("R9", 2'd2, 1, 1, 1, 64'h0000_0000_8000_0003, 64'd40, 6'd33);
        apply("R9", 2'd0, 0, 1, 0, 64'h1, 64'hFFFF, 6'd40);
        apply("R10", 2'd0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 6'd0);
        apply("R10", 2'd1, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 6'd0);
        apply("R11", 2'd1, 0, 0, 1, 64'h0, 64'd3, 6'd0);
        apply("R11", 2'd0, 0, 0, 1, 64'h1, 64'd63, 6'd0);
        apply("R11", 2'd0, 0, 0, 0, 64'h1, 64'd62, 6'd0);
        apply("R12", 2'd3, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 6'd0);

        // Random mix; counts biased toward the boundaries
        for (int k = 0; k < 600; k++) begin
            logic [1:0]  op;
            logic [63:0] s, ar;
            logic        w;
            string       tg;
            op = 2'($urandom_range(0, 3));
            w  = 1'($urandom);
            s  = {$urandom, $urandom};
            ar = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) s[w ? 31 : 63] = 1'b1;
            case ($urandom_range(0, 3))
                0: ar[6:0] = 7'($urandom_range(0, w ? 35 : 70));
                1: ar[6:0] = w ? 7'(31 + $urandom_range(0, 1)) : 7'(63 + $urandom_range(0, 1));
                default: ;
            endcase
            tg = (op == 2'd0) ? "R4" : (op == 2'd1) ? "R4" : (op == 2'd2) ? "R6" : "R12";
            apply(tg, op, w, 1'($urandom_range(0, 4) == 0), 1'($urandom), s, ar, 6'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule